// File: doc/BRIEF.md
# DE-Only Raster Timing Generator

This block produces the raster timing for a 1024 x 600 panel whose sink frames pixels with a data-enable strobe alone. Two cascaded counters walk every pixel position of a frame. A line is 1200 pixel clocks: 1024 active and 176 blanking. A frame is 625 lines: 600 active and 25 blanking. At the nominal 45 MHz pixel clock this gives roughly 60 frames per second.

From each position the block derives five outputs. The first is the data-enable strobe. The second is the active-area column and row, which read zero outside the active window. The third is a one-clock frame-start marker. The last two are active-low horizontal and vertical sync pulses, for downstream sinks that still expect them; the panel itself ignores sync.

The horizontal pulse opens 48 clocks after the last active column and lasts 32 clocks. The vertical pulse covers whole lines, opening 3 lines after the last active row and lasting 6 lines. Every output is registered. A clock enable advances the raster by one position per enabled edge, which lets the block run from a faster system clock.

Top module: `raster_de_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, de, px_x, px_y and frame_start read 0 and hsync_n and vsync_n read 1. Reset places the raster at column 0 of the first blanking line (row V_ACTIVE), so the first frame_start appears on enabled edge V_BLANK*(H_ACTIVE+H_BLANK)+1 after reset.
- R2: Within each frame, de is high for H_ACTIVE consecutive positions on each of the rows 0 to V_ACTIVE-1, and low everywhere else. A line has H_ACTIVE+H_BLANK positions.
- R3: A frame has V_ACTIVE+V_BLANK lines. Consecutive frame_start pulses are exactly (H_ACTIVE+H_BLANK)*(V_ACTIVE+V_BLANK) enabled edges apart.
- R4: When de is high, px_x equals the column (0 at the first active pixel) and px_y equals the row (0 at the first active line). When de is low, both are 0.
- R5: On every line, hsync_n is 0 at columns H_ACTIVE+H_SYNC_OFS through H_ACTIVE+H_SYNC_OFS+H_SYNC_LEN-1 and 1 at all other columns. It is never 0 while de is 1.
- R6: vsync_n is 0 for every position of rows V_ACTIVE+V_SYNC_OFS through V_ACTIVE+V_SYNC_OFS+V_SYNC_LEN-1 and 1 on all other rows.
- R7: frame_start is 1 for exactly one position per frame, column 0 of row 0, together with de=1 and px_x=px_y=0.
- R8: An edge with en=0 changes neither the raster position nor any output.
- R9: Outputs are registered. After an edge with en=1, the outputs show the position that the raster held before that edge, and the raster then moves to the next position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (or system clock qualified by en) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the raster by one position on this edge |
| de | output | 1 | Data-enable strobe, high inside the active window |
| px_x | output | clog2(H_ACTIVE) | Active-area column, 0 during blanking |
| px_y | output | clog2(V_ACTIVE) | Active-area row, 0 during blanking |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| frame_start | output | 1 | One-position marker at the first active pixel of a frame |

## Verification
Every output changes at the enabled edge that consumes a raster position. This follows from one output register behind the counters. The bench therefore drives en on the falling edge and updates its own position model only when en is set. It compares all six outputs at the next falling edge, one edge after the stimulus. The reset value is checked at the falling edge after rst drops, before any enabled edge has been applied. Frame-level counts (first frame_start delay, frame period, de, hsync_n and vsync_n totals) are gathered over uninterrupted enabled edges. These counts are measured in edges, so they carry the same one-edge offset at both ends.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int DEF_H_ACTIVE   = 1024;
  localparam int DEF_H_BLANK    = 176;
  localparam int DEF_H_SYNC_OFS = 48;
  localparam int DEF_H_SYNC_LEN = 32;
  localparam int DEF_V_ACTIVE   = 600;
  localparam int DEF_V_BLANK    = 25;
  localparam int DEF_V_SYNC_OFS = 3;
  localparam int DEF_V_SYNC_LEN = 6;

  function automatic int rt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rt_axis_counter.sv
module rt_axis_counter #(
  parameter int TOTAL = 1200,
  parameter int START = 0,
  parameter int W     = rt_pkg::rt_width(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] START_V = W'(START);
  localparam logic [W-1:0] LAST_V  = W'(TOTAL - 1);

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= START_V;
    end else if (step) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rt_band_decode.sv
module rt_band_decode #(
  parameter int W   = 11,
  parameter int LO  = 0,
  parameter int LEN = 1
) (
  input  logic [W-1:0] pos,
  output logic         hit
);
  localparam int HI = LO + LEN;

  always_comb begin
    hit = (int'(pos) >= LO) && (int'(pos) < HI);
  end
endmodule

// File: rtl/raster_de_timer.sv
module raster_de_timer #(
  parameter int H_ACTIVE   = rt_pkg::DEF_H_ACTIVE,
  parameter int H_BLANK    = rt_pkg::DEF_H_BLANK,
  parameter int H_SYNC_OFS = rt_pkg::DEF_H_SYNC_OFS,
  parameter int H_SYNC_LEN = rt_pkg::DEF_H_SYNC_LEN,
  parameter int V_ACTIVE   = rt_pkg::DEF_V_ACTIVE,
  parameter int V_BLANK    = rt_pkg::DEF_V_BLANK,
  parameter int V_SYNC_OFS = rt_pkg::DEF_V_SYNC_OFS,
  parameter int V_SYNC_LEN = rt_pkg::DEF_V_SYNC_LEN,
  parameter bit SYNC_EN    = 1'b1,
  parameter int XW         = rt_pkg::rt_width(H_ACTIVE),
  parameter int YW         = rt_pkg::rt_width(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          de,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          frame_start
);
  localparam int H_TOTAL = H_ACTIVE + H_BLANK;
  localparam int V_TOTAL = V_ACTIVE + V_BLANK;
  localparam int HW      = rt_pkg::rt_width(H_TOTAL);
  localparam int VW      = rt_pkg::rt_width(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          h_last;
  logic          v_last;
  logic          h_act;
  logic          v_act;
  logic          h_sync_hit;
  logic          v_sync_hit;
  logic          act;
  logic          origin;

  // Column counter: one step per enabled edge.
  rt_axis_counter #(.TOTAL(H_TOTAL), .START(0), .W(HW)) u_hcnt (
    .clk (clk),
    .rst (rst),
    .step(en),
    .cnt (hcnt),
    .last(h_last)
  );

  // Row counter: steps when the column wraps; reset lands on first blanking row.
  rt_axis_counter #(.TOTAL(V_TOTAL), .START(V_ACTIVE), .W(VW)) u_vcnt (
    .clk (clk),
    .rst (rst),
    .step(en & h_last),
    .cnt (vcnt),
    .last(v_last)
  );

  rt_band_decode #(.W(HW), .LO(0), .LEN(H_ACTIVE)) u_h_act (
    .pos(hcnt),
    .hit(h_act)
  );

  rt_band_decode #(.W(VW), .LO(0), .LEN(V_ACTIVE)) u_v_act (
    .pos(vcnt),
    .hit(v_act)
  );

  generate
    if (SYNC_EN) begin : g_sync
      rt_band_decode #(.W(HW), .LO(H_ACTIVE + H_SYNC_OFS), .LEN(H_SYNC_LEN)) u_h_sync (
        .pos(hcnt),
        .hit(h_sync_hit)
      );
      rt_band_decode #(.W(VW), .LO(V_ACTIVE + V_SYNC_OFS), .LEN(V_SYNC_LEN)) u_v_sync (
        .pos(vcnt),
        .hit(v_sync_hit)
      );
    end else begin : g_nosync
      assign h_sync_hit = 1'b0;
      assign v_sync_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    act    = h_act && v_act;
    origin = (hcnt == '0) && (vcnt == '0);
  end

  // Output register: captures the position consumed by this enabled edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      de          <= 1'b0;
      px_x        <= '0;
      px_y        <= '0;
      hsync_n     <= 1'b1;
      vsync_n     <= 1'b1;
      frame_start <= 1'b0;
    end else if (en) begin
      de          <= act;
      px_x        <= act ? hcnt[XW-1:0] : '0;
      px_y        <= act ? vcnt[YW-1:0] : '0;
      hsync_n     <= ~h_sync_hit;
      vsync_n     <= ~v_sync_hit;
      frame_start <= origin;
    end
  end

  logic unused_v_last;
  assign unused_v_last = v_last;
endmodule

// File: rtl/raster_de_timer_chk.sv
module raster_de_timer_chk #(
  parameter int H_ACTIVE = 1024,
  parameter int XW       = 10,
  parameter int YW       = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          de,
  input logic [XW-1:0] px_x,
  input logic [YW-1:0] px_y,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          frame_start
);
  p_blank_coords_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !de |-> (px_x == '0) && (px_y == '0));

  p_x_advances_r4: assert property (@(posedge clk) disable iff (rst)
    (de && en && (int'(px_x) < H_ACTIVE - 1)) |=> de && (px_x == $past(px_x) + 1'b1));

  p_hsync_outside_active_r5: assert property (@(posedge clk) disable iff (rst)
    de |-> hsync_n);

  p_fs_at_origin_r7: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> de && (px_x == '0) && (px_y == '0));

  p_fs_single_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_start && en) |=> !frame_start);

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(de) && $stable(px_x) && $stable(px_y) && $stable(hsync_n)
            && $stable(vsync_n) && $stable(frame_start));
endmodule

bind raster_de_timer raster_de_timer_chk #(
  .H_ACTIVE(H_ACTIVE),
  .XW      (XW),
  .YW      (YW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .de         (de),
  .px_x       (px_x),
  .px_y       (px_y),
  .hsync_n    (hsync_n),
  .vsync_n    (vsync_n),
  .frame_start(frame_start)
);

// File: tb/raster_de_timer_bench.sv
module raster_de_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 16, HB = 10, HSO = 3, HSL = 4;
  localparam int VA = 6,  VB = 5,  VSO = 1, VSL = 2;
  localparam int HT = HA + HB;
  localparam int VT = VA + VB;
  localparam int XW = $clog2(HA);
  localparam int YW = $clog2(VA);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic          de;
  logic [XW-1:0] px_x;
  logic [YW-1:0] px_y;
  logic          hsync_n;
  logic          vsync_n;
  logic          frame_start;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // bench raster model
  int bh, bv;
  int e_de, e_x, e_y, e_hs, e_vs, e_fs;

  always #(CLK_PERIOD / 2) clk = ~clk;

  raster_de_timer #(
    .H_ACTIVE(HA), .H_BLANK(HB), .H_SYNC_OFS(HSO), .H_SYNC_LEN(HSL),
    .V_ACTIVE(VA), .V_BLANK(VB), .V_SYNC_OFS(VSO), .V_SYNC_LEN(VSL)
  ) u_raster_de_timer (
    .clk(clk), .rst(rst), .en(en), .de(de), .px_x(px_x), .px_y(px_y),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .frame_start(frame_start)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int f_de(input int h, input int v);
    return (h < HA && v < VA) ? 1 : 0;
  endfunction

  task automatic expect_reset_vals();
    e_de = 0; e_x = 0; e_y = 0; e_hs = 1; e_vs = 1; e_fs = 0;
  endtask

  task automatic model_consume();
    e_de = f_de(bh, bv);
    e_x  = e_de ? bh : 0;
    e_y  = e_de ? bv : 0;
    e_hs = (bh >= HA + HSO && bh < HA + HSO + HSL) ? 0 : 1;
    e_vs = (bv >= VA + VSO && bv < VA + VSO + VSL) ? 0 : 1;
    e_fs = (bh == 0 && bv == 0) ? 1 : 0;
    bh++;
    if (bh == HT) begin
      bh = 0;
      bv = (bv == VT - 1) ? 0 : bv + 1;
    end
  endtask

  task automatic check_all(input string why);
    cmp({why, " R2 de"}, int'(de), e_de);
    cmp({why, " R4 px_x"}, int'(px_x), e_x);
    cmp({why, " R4 px_y"}, int'(px_y), e_y);
    cmp({why, " R5 hsync_n"}, int'(hsync_n), e_hs);
    cmp({why, " R6 vsync_n"}, int'(vsync_n), e_vs);
    cmp({why, " R7 frame_start"}, int'(frame_start), e_fs);
  endtask

  // one edge: drive at falling edge, compare at next falling edge (R9)
  task automatic tick(input bit e, input string why);
    en = e;
    if (e) model_consume();
    @(posedge clk);
    @(negedge clk);
    check_all(why);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_reset_vals();
    check_all("R1 in-reset");
    rst = 1'b0;
    bh = 0;
    bv = VA;
    @(posedge clk);
    @(negedge clk);
    // en was 1 at this edge: first position consumed
    model_consume();
    check_all("R1 first-edge");
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int edges, de_cnt, hs_cnt, vs_cnt;
    void'($urandom(32'd4711));
    @(negedge clk);
    // R1: reset state with en low
    rst = 1'b1;
    en  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_reset_vals();
    check_all("R1 reset");
    rst = 1'b0;
    bh = 0;
    bv = VA;
    expect_reset_vals();
    @(negedge clk);
    check_all("R1 post-reset idle R8");

    // R8/R9: constrained random enable over several frames
    for (int i = 0; i < 3000; i++) begin
      tick(($urandom_range(3, 0) != 0), "rand");
    end

    // R8: long idle stretch holds everything
    for (int i = 0; i < 20; i++) tick(1'b0, "R8 idle");

    // Directed: reset mid-frame, measure first frame_start (R1)
    do_reset();
    edges = 1;
    while (frame_start !== 1'b1 && edges < 10 * HT * VT) begin
      tick(1'b1, "R1 run");
      edges++;
    end
    cmp("R1 first frame_start edge", edges, VB * HT + 1);

    // R2/R3/R5/R6: one full frame of counts
    edges = 0; de_cnt = 0; hs_cnt = 0; vs_cnt = 0;
    do begin
      if (de === 1'b1) de_cnt++;
      if (hsync_n === 1'b0) hs_cnt++;
      if (vsync_n === 1'b0) vs_cnt++;
      tick(1'b1, "R3 run");
      edges++;
    end while (frame_start !== 1'b1 && edges < 10 * HT * VT);
    cmp("R3 frame period", edges, HT * VT);
    cmp("R2 de per frame", de_cnt, HA * VA);
    cmp("R5 hsync_n low per frame", hs_cnt, HSL * VT);
    cmp("R6 vsync_n low per frame", vs_cnt, VSL * HT);

    // R8: pause right on frame_start, marker must persist then clear (R7)
    tick(1'b0, "R8 pause at fs");
    cmp("R8 fs held", int'(frame_start), 1);
    tick(1'b1, "R7 after fs");
    cmp("R7 fs single", int'(frame_start), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule